// File: doc/BRIEF.md
# Two-Stage Routed Event Interrupt Controller

The controller collects a wide vector of system event lines and routes them to a small set of host interrupt lines. Routing is programmable and takes two stages. Each event names a channel, and several events may share one channel. Each channel then names a host line, and several channels may share one host. Each event has a latched pending bit and an enable bit. It also has a polarity bit and a type bit, which select level or edge detection.

Software reaches every control through a 32-bit register port with a single-cycle write strobe and a read strobe. Read data appears one cycle after the read strobe. Individual bits are changed either by writing an event or host index to an indexed register, or by writing a bit mask in which only the 1 bits act. For each host, a read-only word reports the single most urgent pending, enabled event routed to that host, or reports that there is none. A host line asserts only when a global enable and that host's own enable are both set.

Top module: `evroute_intc`

## Requirements
- R1: An event's active level is its input when its polarity bit is 1 and the inverted input when it is 0. With type bit 0 the pending bit is set on an inactive-to-active transition of the registered active level. With type bit 1 it is set in every cycle in which that level is active. The pending bit is set two clock edges after the input changes. Polarity words sit at 0xD00 (events 0..31) and 0xD04 (events 32..63). Type words sit at 0xD80 and 0xD84. Bit k of a word belongs to event 32*w+k.
- R2: A write of an event index v to 0x20 sets pending bit v, and to 0x24 clears it. A write of v to 0x28 sets enable bit v, and to 0x2C clears it. A value of 64 or more changes nothing. Pending status reads back at 0x200/0x204 and enables read back at 0x300/0x304, with the bit layout of R1.
- R3: Mask writes change only the bits written as 1. A write to 0x300/0x304 sets enables, a write to 0x380/0x384 clears enables, and a write to 0x280/0x284 clears pending bits.
- R4: A write of host index h to 0x34 sets host enable h, and to 0x38 clears it. A value of 10 or more changes nothing. A host line is low while its enable is clear.
- R5: The channel of event e is held in word 0x400+4*(e/4), in bits [8*(e%4)+3 : 8*(e%4)]. The upper nibble of each byte is ignored and reads 0.
- R6: The host of channel c is held in word 0x800+4*(c/4), with the same byte and nibble packing as R5. Byte lanes of channels 10 and 11 read 0.
- R7: The word at 0x900+4*h reads 0x80000000 when no pending, enabled event routes to host h. Otherwise bits 9:0 carry an event index. The index comes from the lowest-numbered channel that routes to h and has a pending, enabled event, and within that channel it is the lowest event index.
- R8: host_irq[h] is registered. It is 1 one edge after the global enable, host enable h and at least one pending, enabled event routed to h are all true.
- R9: Bit 0 of the word at 0x10 is the global enable. While it is 0, every host line is low.
- R10: When a hardware event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R11: After reset, every map, enable and pending bit, the global enable and all outputs are 0. Polarity bits reset to 1 and type bits reset to 0.
- R12: bus_rdata presents the addressed word one edge after bus_re. It is 0 in cycles without a read and for addresses that hold no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_re |
| ev_in | input | 64 | System event lines |
| host_irq | output | 10 | Host interrupt lines |

## Verification
Routing is first tried with two events sharing one channel and a third event on a lower channel that maps to the same host. Comparing the priority word in each case shows whether channel order takes precedence over event index. Pending, enable and host gating are each toggled through both the indexed port and the mask port, and all-zero masks and out-of-range indexes check that nothing else moves. On the input side the test uses a single pulse, a held level under edge mode and then under level mode, where the level case also collides with a clear, and a polarity flip. Together these separate edge from level detection, show that set wins over clear, and show that a polarity change alone creates an edge.

// File: rtl/evroute_pkg.sv
package evroute_pkg;
  localparam int A_GLOBAL   = 'h010;
  localparam int A_PSET_IX  = 'h020;
  localparam int A_PCLR_IX  = 'h024;
  localparam int A_ESET_IX  = 'h028;
  localparam int A_ECLR_IX  = 'h02C;
  localparam int A_HSET_IX  = 'h034;
  localparam int A_HCLR_IX  = 'h038;
  localparam int A_PRAW     = 'h200;
  localparam int A_PCLR_MK  = 'h280;
  localparam int A_ESET_MK  = 'h300;
  localparam int A_ECLR_MK  = 'h380;
  localparam int A_CMAP     = 'h400;
  localparam int A_HMAP     = 'h800;
  localparam int A_PRIO     = 'h900;
  localparam int A_POL      = 'hD00;
  localparam int A_TYPE     = 'hD80;
  localparam logic [31:0] PRIO_NONE = 32'h8000_0000;
endpackage

// File: rtl/evroute_detect.sv
module evroute_detect #(
  parameter int NE = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] ev_in,
  input  logic [NE-1:0] pol,
  input  logic [NE-1:0] lvl,
  output logic [NE-1:0] hit
);
  logic [NE-1:0] act, act_q, act_qq;

  assign act = ~(ev_in ^ pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      act_qq <= '0;
    end else begin
      act_q  <= act;
      act_qq <= act_q;
    end
  end

  assign hit = (lvl & act_q) | (~lvl & act_q & ~act_qq);
endmodule

// File: rtl/evroute_prio.sv
module evroute_prio #(
  parameter int NE  = 64,
  parameter int NC  = 10,
  parameter int NH  = 10,
  parameter int CW  = 4,
  parameter int EIW = 6
) (
  input  logic [NE-1:0]  pend,
  input  logic [CW-1:0]  cmap [NE],
  input  logic [CW-1:0]  hmap [NC],
  output logic [NH-1:0]  host_any,
  output logic [EIW-1:0] host_idx [NH]
);
  logic [NC-1:0]  ch_any;
  logic [EIW-1:0] ch_idx [NC];

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic           l_any;
    logic [EIW-1:0] l_idx;
    always_comb begin
      l_any = 1'b0;
      l_idx = '0;
      for (int e = NE - 1; e >= 0; e--) begin
        if (pend[e] && cmap[e] == CW'(c)) begin
          l_any = 1'b1;
          l_idx = EIW'(e);
        end
      end
    end
    assign ch_any[c] = l_any;
    assign ch_idx[c] = l_idx;
  end

  for (genvar h = 0; h < NH; h++) begin : g_host
    logic           l_any;
    logic [EIW-1:0] l_idx;
    always_comb begin
      l_any = 1'b0;
      l_idx = '0;
      for (int c = NC - 1; c >= 0; c--) begin
        if (ch_any[c] && hmap[c] == CW'(h)) begin
          l_any = 1'b1;
          l_idx = ch_idx[c];
        end
      end
    end
    assign host_any[h] = l_any;
    assign host_idx[h] = l_idx;
  end
endmodule

// File: rtl/evroute_intc.sv
module evroute_intc #(
  parameter int NE = 64,
  parameter int NC = 10,
  parameter int NH = 10,
  parameter int AW = 12,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [31:0]   bus_rdata,
  input  logic [NE-1:0] ev_in,
  output logic [NH-1:0] host_irq
);
  import evroute_pkg::*;

  localparam int EIW = $clog2(NE);
  localparam int HIW = $clog2(NH);
  localparam int MW  = NE / 32;

  logic [NE-1:0]  status, st_n, en, en_n, pol, lvl, hit;
  logic [NH-1:0]  hen, prio_any;
  logic           gen;
  logic [CW-1:0]  cmap [NE];
  logic [CW-1:0]  hmap [NC];
  logic [EIW-1:0] prio_idx [NH];
  logic [31:0]    rd_v;
  logic           ev_ok, h_ok;

  assign ev_ok = bus_wdata < 32'(NE);
  assign h_ok  = bus_wdata < 32'(NH);

  evroute_detect #(.NE(NE)) det_i (
    .clk(clk), .rst(rst), .ev_in(ev_in), .pol(pol), .lvl(lvl), .hit(hit)
  );

  evroute_prio #(.NE(NE), .NC(NC), .NH(NH), .CW(CW), .EIW(EIW)) prio_i (
    .pend(status & en), .cmap(cmap), .hmap(hmap),
    .host_any(prio_any), .host_idx(prio_idx)
  );

  // next pending / enable state: software first, hardware set last
  always_comb begin
    st_n = status;
    en_n = en;
    if (bus_we) begin
      if (bus_addr == AW'(A_PSET_IX) && ev_ok) st_n[bus_wdata[EIW-1:0]] = 1'b1;
      if (bus_addr == AW'(A_PCLR_IX) && ev_ok) st_n[bus_wdata[EIW-1:0]] = 1'b0;
      if (bus_addr == AW'(A_ESET_IX) && ev_ok) en_n[bus_wdata[EIW-1:0]] = 1'b1;
      if (bus_addr == AW'(A_ECLR_IX) && ev_ok) en_n[bus_wdata[EIW-1:0]] = 1'b0;
      for (int w = 0; w < MW; w++) begin
        if (bus_addr == AW'(A_PCLR_MK + 4*w)) st_n[w*32 +: 32] = st_n[w*32 +: 32] & ~bus_wdata;
        if (bus_addr == AW'(A_ESET_MK + 4*w)) en_n[w*32 +: 32] = en_n[w*32 +: 32] | bus_wdata;
        if (bus_addr == AW'(A_ECLR_MK + 4*w)) en_n[w*32 +: 32] = en_n[w*32 +: 32] & ~bus_wdata;
      end
    end
    st_n = st_n | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      en     <= '0;
      pol    <= '1;
      lvl    <= '0;
      gen    <= 1'b0;
      hen    <= '0;
    end else begin
      status <= st_n;
      en     <= en_n;
      if (bus_we) begin
        if (bus_addr == AW'(A_GLOBAL)) gen <= bus_wdata[0];
        if (bus_addr == AW'(A_HSET_IX) && h_ok) hen[bus_wdata[HIW-1:0]] <= 1'b1;
        if (bus_addr == AW'(A_HCLR_IX) && h_ok) hen[bus_wdata[HIW-1:0]] <= 1'b0;
        for (int w = 0; w < MW; w++) begin
          if (bus_addr == AW'(A_POL + 4*w))  pol[w*32 +: 32] <= bus_wdata;
          if (bus_addr == AW'(A_TYPE + 4*w)) lvl[w*32 +: 32] <= bus_wdata;
        end
      end
    end
  end

  // routing tables, one byte lane per entry, low nibble used
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NE; e++) cmap[e] <= '0;
      for (int c = 0; c < NC; c++) hmap[c] <= '0;
    end else if (bus_we) begin
      for (int e = 0; e < NE; e++)
        if (bus_addr == AW'(A_CMAP + 4*(e/4))) cmap[e] <= bus_wdata[8*(e%4) +: CW];
      for (int c = 0; c < NC; c++)
        if (bus_addr == AW'(A_HMAP + 4*(c/4))) hmap[c] <= bus_wdata[8*(c%4) +: CW];
    end
  end

  always_comb begin
    rd_v = '0;
    if (bus_addr == AW'(A_GLOBAL)) rd_v = {31'b0, gen};
    for (int w = 0; w < MW; w++) begin
      if (bus_addr == AW'(A_PRAW + 4*w))    rd_v = status[w*32 +: 32];
      if (bus_addr == AW'(A_ESET_MK + 4*w)) rd_v = en[w*32 +: 32];
      if (bus_addr == AW'(A_POL + 4*w))     rd_v = pol[w*32 +: 32];
      if (bus_addr == AW'(A_TYPE + 4*w))    rd_v = lvl[w*32 +: 32];
    end
    for (int e = 0; e < NE; e++)
      if (bus_addr == AW'(A_CMAP + 4*(e/4))) rd_v[8*(e%4) +: CW] = cmap[e];
    for (int c = 0; c < NC; c++)
      if (bus_addr == AW'(A_HMAP + 4*(c/4))) rd_v[8*(c%4) +: CW] = hmap[c];
    for (int h = 0; h < NH; h++)
      if (bus_addr == AW'(A_PRIO + 4*h))
        rd_v = prio_any[h] ? {22'b0, 10'(prio_idx[h])} : PRIO_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      host_irq  <= '0;
    end else begin
      bus_rdata <= bus_re ? rd_v : 32'h0;
      host_irq  <= prio_any & hen & {NH{gen}};
    end
  end
endmodule

// File: rtl/evroute_intc_chk.sv
module evroute_intc_chk #(
  parameter int NE = 64,
  parameter int NH = 10,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_we,
  input logic          bus_re,
  input logic [31:0]   bus_rdata,
  input logic [NH-1:0] host_irq,
  input logic          gen,
  input logic [NH-1:0] hen,
  input logic [NE-1:0] status,
  input logic [NE-1:0] en,
  input logic [NH-1:0] prio_any
);
  localparam int EIW = $clog2(NE);

  assert_irq_global_R9: assert property (@(posedge clk) disable iff (rst)
    (|host_irq) |-> $past(gen));

  assert_irq_hosten_R4: assert property (@(posedge clk) disable iff (rst)
    (host_irq & ~$past(hen)) == '0);

  assert_idx_set_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'('h020) && bus_wdata < 32'(NE))
      |=> status[$past(bus_wdata[EIW-1:0])]);

  assert_prio_none_R7: assert property (@(posedge clk) disable iff (rst)
    ((status & en) == '0) |-> (prio_any == '0));

  assert_rdata_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_re) |-> (bus_rdata == 32'h0));
endmodule

bind evroute_intc evroute_intc_chk #(.NE(NE), .NH(NH), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
  .host_irq(host_irq), .gen(gen), .hen(hen), .status(status), .en(en),
  .prio_any(prio_any)
);

// File: tb/evroute_intc_tb.sv
module evroute_intc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 64;
  localparam int NH = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NE-1:0] ev_in = '0;
  logic [NH-1:0] host_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evroute_intc dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .ev_in(ev_in), .host_irq(host_irq)
  );

  function automatic void check(logic [31:0] act, logic [31:0] exp, string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endfunction

  // monitor: compare each read result against the queued expectation
  always @(posedge clk) rd_d <= bus_re;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R12: unexpected read result 0x%08h", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata, e, t);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    bus_addr = 12'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = 12'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk_irq(logic [NH-1:0] exp, string tag);
    check(32'(host_irq), 32'(exp), tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state (R11)
    rd('h010, 32'h0, "R11 global enable");
    rd('h908, 32'h8000_0000, "R11 prio none");
    rd('hD00, 32'hFFFF_FFFF, "R11 polarity");
    rd('hD84, 32'h0, "R11 type");
    rd('h200, 32'h0, "R11 pending");
    chk_irq('0, "R11 host_irq");
    // routing tables (R5 R6): ev5->ch3, ev40->ch3, ev12->ch1, ch3->h2, ch1->h2
    wr('h404, 32'h0000_F3F0);
    wr('h428, 32'h3);
    wr('h40C, 32'h1);
    wr('h800, 32'h0200_0200);
    rd('h404, 32'h0000_0300, "R5 cmap packing");
    rd('h800, 32'h0200_0200, "R6 hmap packing");
    rd('h808, 32'h0, "R6 hmap upper word");
    // indexed pending and enable (R2 R7)
    wr('h020, 40);
    rd('h204, 32'h100, "R2 idx set pending");
    rd('h908, 32'h8000_0000, "R7 disabled not reported");
    wr('h028, 40);
    rd('h908, 32'd40, "R7 single event");
    chk_irq('0, "R9 no global");
    wr('h034, 2); idle(1);
    chk_irq('0, "R9 host on global off");
    wr('h010, 1); idle(1);
    chk_irq(10'h004, "R8 all enabled");
    // priority ordering (R7)
    wr('h300, 32'h20);
    wr('h020, 5);
    rd('h908, 32'd5, "R7 lower event same channel");
    wr('h020, 12);
    wr('h028, 12);
    rd('h908, 32'd12, "R7 lower channel wins");
    wr('h024, 12);
    rd('h908, 32'd5, "R2 idx clear pending");
    wr('h280, 32'h20);
    rd('h908, 32'd40, "R3 mask clear pending");
    wr('h284, 32'h0);
    rd('h204, 32'h100, "R3 zero mask no effect");
    wr('h384, 32'h100);
    rd('h908, 32'h8000_0000, "R3 mask clear enable");
    chk_irq('0, "R8 none pending");
    rd('h300, 32'h1020, "R2 enable readback");
    // host and global gating (R4 R9)
    wr('h028, 40); idle(1);
    chk_irq(10'h004, "R8 re-enabled");
    wr('h038, 2); idle(1);
    chk_irq('0, "R4 host disabled");
    wr('h034, 12); idle(1);
    chk_irq('0, "R4 out-of-range host idx");
    wr('h034, 2); idle(1);
    chk_irq(10'h004, "R4 host re-enabled");
    wr('h010, 0); idle(1);
    chk_irq('0, "R9 global off");
    wr('h010, 1);
    // out-of-range event index (R2)
    wr('h020, 64);
    rd('h200, 32'h0, "R2 idx 64 ignored lo");
    rd('h204, 32'h100, "R2 idx 64 ignored hi");
    wr('h284, 32'h100);
    rd('h908, 32'h8000_0000, "R3 cleared ev40");
    // edge detection (R1)
    ev_in[5] = 1'b1; idle(1);
    ev_in[5] = 1'b0; idle(2);
    rd('h200, 32'h20, "R1 pulse latched");
    chk_irq(10'h004, "R8 from input event");
    wr('h024, 5);
    ev_in[12] = 1'b1; idle(2);
    rd('h200, 32'h1000, "R1 rising edge");
    wr('h024, 12); idle(2);
    rd('h200, 32'h0, "R1 held level no re-set in edge mode");
    // level mode and collision (R1 R10)
    wr('hD80, 32'h1000); idle(2);
    rd('h200, 32'h1000, "R1 level mode");
    wr('h024, 12);
    rd('h200, 32'h1000, "R10 set beats clear");
    ev_in[12] = 1'b0; idle(2);
    wr('h024, 12);
    rd('h200, 32'h0, "R1 level gone");
    wr('hD80, 32'h0);
    // polarity (R1)
    wr('hD00, 32'hFFFF_FF7F); idle(2);
    rd('h200, 32'h80, "R1 polarity flip edge");
    wr('h024, 7);
    ev_in[7] = 1'b1; idle(2);
    rd('h200, 32'h0, "R1 inactive high on low polarity");
    ev_in[7] = 1'b0; idle(2);
    rd('h200, 32'h80, "R1 falling edge active low");
    rd('h0F0, 32'h0, "R12 unmapped address");
    idle(3);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R12: actual %0d reads pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule